// File: doc/BRIEF.md
# Interleaving Fetch Request Router

The router sits between four instruction-fetch initiators and three fetch targets. Target 0 is the non-cacheable path to memory. Targets 1 and 2 are two cache banks that share the cacheable space by interleaving on the lowest set-index bit. Each initiator raises one request at a time with a valid/ready handshake. The router decodes the 20-bit fetch address against a programmable cacheable window and picks a target. A round-robin arbiter per target resolves contention. A request bound for a bank is forwarded with the bank-select bit removed, and the response beats travel back to the initiator that issued the request.

The window is a start register, an end register and an enable flag, written through a small configuration port. After reset the window covers the whole address space but is switched off, so every fetch goes to target 0 until software turns it on. The address is split as follows: byte offset in bits [7:0] for a 256-byte line, set index in bits [13:8] with bit 8 choosing the bank, and tag above that.

Each target owns a three-state arbiter: `ARB_IDLE` (no owner), `ARB_ISSUE` (request presented to the target) and `ARB_WAIT` (owner waits for response beats). The transition *grant* moves IDLE to ISSUE when any initiator requests that target. *Accept* moves ISSUE to WAIT when the target raises ready. *Complete* moves WAIT to IDLE on the beat flagged last.

Top module: `fetch_router`

## Requirements
- R1: After reset no target valid, initiator ready or response valid is high. The window is disabled, so every fetch goes to target 0 with its address unchanged.
- R2: A configuration write with select 0 loads the window start, select 1 loads the window end and select 2 loads the enable from data bit 0. Select 3 changes nothing. Start resets to 0x00000 and end to 0xFFFFF. An address is cacheable only when enabled and start <= address <= end, with both bounds inclusive.
- R3: A non-cacheable fetch, single or burst, goes to target 0 with its full 20-bit address and its length field unchanged.
- R4: A cacheable fetch goes to target 1 when address bit 8 is 0 and to target 2 when it is 1. The forwarded address is {0, address[19:9], address[7:0]}, so its bit 19 is always 0 on a bank.
- R5: A target's valid stays high with stable address and length until the target raises ready. The owning initiator's ready is high in exactly that accepting cycle.
- R6: A target serves one request at a time and keeps its owner until the last response beat. Among waiting initiators it grants the first one found by counting upward from the initiator after the one served last, starting at initiator 0 after reset.
- R7: Every response beat (valid, data, last flag) from a target appears only on the initiator that owns that target. The length field gives the number of beats minus one.
- R8: A request that is raised while its target is idle gives target valid in the next cycle.
- R9: The three targets work independently. Requests to different targets that are raised in the same cycle are all presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 20 | Configuration write data |
| ini_valid | input | 4 | Request valid per initiator |
| ini_ready | output | 4 | Request accepted per initiator |
| ini_addr | input | 80 | Fetch address per initiator, 20 bits each |
| ini_len | input | 8 | Beats minus one per initiator, 2 bits each |
| ini_rsp_valid | output | 4 | Response beat valid per initiator |
| ini_rsp_last | output | 4 | Final response beat per initiator |
| ini_rsp_data | output | 512 | Response data per initiator, 128 bits each |
| tgt_valid | output | 3 | Request valid per target |
| tgt_ready | input | 3 | Target accepts request |
| tgt_addr | output | 60 | Forwarded address per target |
| tgt_len | output | 6 | Forwarded length per target |
| tgt_rvalid | input | 3 | Response beat valid per target |
| tgt_rlast | input | 3 | Final response beat per target |
| tgt_rdata | input | 384 | Response data per target |

## Verification
Two functions can fall in the same cycle: response beats from different targets returning to different initiators, and a grant at one target while another target's owner is still receiving data. The bench provokes both with four initiators running random addresses at once against responders that have random ready, random start delay and random gaps between beats. Each beat carries its target number and the forwarded address. An initiator therefore judges every beat against its own expected route and stripped address, and a misrouted beat shows up as wrong data on the wrong port.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int N_TGT = 3;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_ISSUE = 2'd1,
        ARB_WAIT  = 2'd2
    } arb_state_e;

    localparam logic [1:0] RT_UNCACHED = 2'd0;
    localparam logic [1:0] RT_BANK_LO  = 2'd1;
    localparam logic [1:0] RT_BANK_HI  = 2'd2;

    localparam logic [1:0] SEL_START  = 2'd0;
    localparam logic [1:0] SEL_END    = 2'd1;
    localparam logic [1:0] SEL_ENABLE = 2'd2;
endpackage

// File: rtl/fr_window.sv
module fr_window
    import fr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] win_start,
    output logic [ADDR_W-1:0] win_end,
    output logic              win_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_start <= '0;
            win_end   <= '1;
            win_en    <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_START:  win_start <= cfg_wdata;
                SEL_END:    win_end   <= cfg_wdata;
                SEL_ENABLE: win_en    <= cfg_wdata[0];
                default:    ;
            endcase
        end
    end

    // R2: the unused select leaves every window register untouched
    p_sel_spare_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(win_start) && $stable(win_end) && $stable(win_en)));
endmodule

// File: rtl/fr_decode.sv
module fr_decode
    import fr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] win_start,
    input  logic [ADDR_W-1:0] win_end,
    input  logic              win_en,
    output logic [1:0]        route,
    output logic [ADDR_W-1:0] bank_addr
);
    localparam int BSEL = OFF_W;

    logic in_window;

    always_comb begin
        in_window = win_en && (addr >= win_start) && (addr <= win_end);
        if (!in_window)
            route = RT_UNCACHED;
        else if (addr[BSEL])
            route = RT_BANK_HI;
        else
            route = RT_BANK_LO;
        bank_addr = {1'b0, addr[ADDR_W-1:BSEL+1], addr[BSEL-1:0]};
    end
endmodule

// File: rtl/fr_arbiter.sv
module fr_arbiter
    import fr_pkg::*;
#(
    parameter int N_INI  = 4,
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 2,
    localparam int IW    = $clog2(N_INI)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_INI-1:0]        req,
    input  logic [N_INI*ADDR_W-1:0] cand_addr,
    input  logic [N_INI*LEN_W-1:0]  cand_len,
    input  logic                    tgt_ready,
    input  logic                    tgt_rvalid,
    input  logic                    tgt_rlast,
    output logic                    tgt_valid,
    output logic [ADDR_W-1:0]       tgt_addr,
    output logic [LEN_W-1:0]        tgt_len,
    output logic                    accept,
    output logic                    serving,
    output logic [IW-1:0]           owner
);
    arb_state_e        st_q, st_d;
    logic [IW-1:0]     own_q, own_d;
    logic [IW-1:0]     ptr_q, ptr_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              load;
    logic              pick_hit;
    logic [IW-1:0]     pick_id;

    // round-robin search starting at the pointer; lowest distance wins
    always_comb begin
        pick_hit = 1'b0;
        pick_id  = '0;
        for (int k = N_INI - 1; k >= 0; k--) begin
            logic [IW-1:0] slot;
            slot = IW'((int'(ptr_q) + k) % N_INI);
            if (req[slot]) begin
                pick_hit = 1'b1;
                pick_id  = slot;
            end
        end
    end

    // next state: grant, accept, complete
    always_comb begin
        st_d  = st_q;
        own_d = own_q;
        ptr_d = ptr_q;
        load  = 1'b0;
        unique case (st_q)
            ARB_IDLE: begin
                if (pick_hit) begin
                    st_d  = ARB_ISSUE;
                    own_d = pick_id;
                    load  = 1'b1;
                end
            end
            ARB_ISSUE: begin
                if (tgt_ready) st_d = ARB_WAIT;
            end
            ARB_WAIT: begin
                if (tgt_rvalid && tgt_rlast) begin
                    st_d  = ARB_IDLE;
                    ptr_d = IW'((int'(own_q) + 1) % N_INI);
                end
            end
            default: st_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ARB_IDLE;
            own_q  <= '0;
            ptr_q  <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
            ptr_q <= ptr_d;
            if (load) begin
                addr_q <= cand_addr[int'(pick_id)*ADDR_W +: ADDR_W];
                len_q  <= cand_len[int'(pick_id)*LEN_W +: LEN_W];
            end
        end
    end

    // outputs
    always_comb begin
        tgt_valid = (st_q == ARB_ISSUE);
        accept    = (st_q == ARB_ISSUE) && tgt_ready;
        serving   = (st_q == ARB_WAIT);
        tgt_addr  = addr_q;
        tgt_len   = len_q;
        owner     = own_q;
    end

    // R5: an unaccepted request holds its contents
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_addr) && $stable(tgt_len)));

    // R6: owner is kept until the final beat
    p_owner_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ARB_IDLE) && !(st_q == ARB_WAIT && tgt_rvalid && tgt_rlast)) |=> $stable(own_q));

    // R6: a grant only goes to an initiator that was requesting
    p_grant_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_valid) |-> (($past(req) & (N_INI'(1) << own_q)) != '0));
endmodule

// File: rtl/fetch_router.sv
module fetch_router
    import fr_pkg::*;
#(
    parameter int N_INI  = 4,
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 8,
    parameter int LEN_W  = 2,
    parameter int DATA_W = 128,
    localparam int IW    = $clog2(N_INI)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [ADDR_W-1:0]       cfg_wdata,
    input  logic [N_INI-1:0]        ini_valid,
    output logic [N_INI-1:0]        ini_ready,
    input  logic [N_INI*ADDR_W-1:0] ini_addr,
    input  logic [N_INI*LEN_W-1:0]  ini_len,
    output logic [N_INI-1:0]        ini_rsp_valid,
    output logic [N_INI-1:0]        ini_rsp_last,
    output logic [N_INI*DATA_W-1:0] ini_rsp_data,
    output logic [N_TGT-1:0]        tgt_valid,
    input  logic [N_TGT-1:0]        tgt_ready,
    output logic [N_TGT*ADDR_W-1:0] tgt_addr,
    output logic [N_TGT*LEN_W-1:0]  tgt_len,
    input  logic [N_TGT-1:0]        tgt_rvalid,
    input  logic [N_TGT-1:0]        tgt_rlast,
    input  logic [N_TGT*DATA_W-1:0] tgt_rdata
);
    logic [ADDR_W-1:0] win_start, win_end;
    logic              win_en;

    logic [N_INI-1:0][1:0]                 route;
    logic [N_INI-1:0][ADDR_W-1:0]          bank_addr;
    logic [N_TGT-1:0][N_INI-1:0]           req_vec;
    logic [N_TGT-1:0][N_INI*ADDR_W-1:0]    cand_addr;
    logic [N_TGT-1:0]                      accept, serving;
    logic [N_TGT-1:0][IW-1:0]              owner;
    logic [N_INI-1:0][N_TGT-1:0]           own_match;

    fr_window #(.ADDR_W(ADDR_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win_start (win_start),
        .win_end   (win_end),
        .win_en    (win_en)
    );

    for (genvar i = 0; i < N_INI; i++) begin : g_ini
        fr_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
            .addr      (ini_addr[i*ADDR_W +: ADDR_W]),
            .win_start (win_start),
            .win_end   (win_end),
            .win_en    (win_en),
            .route     (route[i]),
            .bank_addr (bank_addr[i])
        );
    end

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        always_comb begin
            for (int i = 0; i < N_INI; i++) begin
                req_vec[t][i] = ini_valid[i] && (route[i] == 2'(t));
                if (t == 0)
                    cand_addr[t][i*ADDR_W +: ADDR_W] = ini_addr[i*ADDR_W +: ADDR_W];
                else
                    cand_addr[t][i*ADDR_W +: ADDR_W] = bank_addr[i];
            end
        end

        fr_arbiter #(.N_INI(N_INI), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req_vec[t]),
            .cand_addr  (cand_addr[t]),
            .cand_len   (ini_len),
            .tgt_ready  (tgt_ready[t]),
            .tgt_rvalid (tgt_rvalid[t]),
            .tgt_rlast  (tgt_rlast[t]),
            .tgt_valid  (tgt_valid[t]),
            .tgt_addr   (tgt_addr[t*ADDR_W +: ADDR_W]),
            .tgt_len    (tgt_len[t*LEN_W +: LEN_W]),
            .accept     (accept[t]),
            .serving    (serving[t]),
            .owner      (owner[t])
        );
    end

    // steer acceptance and response beats back to each target's owner
    always_comb begin
        ini_ready     = '0;
        ini_rsp_valid = '0;
        ini_rsp_last  = '0;
        ini_rsp_data  = '0;
        for (int i = 0; i < N_INI; i++) begin
            for (int t = 0; t < N_TGT; t++) begin
                own_match[i][t] = serving[t] && (owner[t] == IW'(i));
                if (accept[t] && owner[t] == IW'(i))
                    ini_ready[i] = 1'b1;
                if (own_match[i][t] && tgt_rvalid[t]) begin
                    ini_rsp_valid[i]                 = 1'b1;
                    ini_rsp_last[i]                  = tgt_rlast[t];
                    ini_rsp_data[i*DATA_W +: DATA_W] = tgt_rdata[t*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar t = 1; t < N_TGT; t++) begin : g_bank_chk
        // R2: banks are only granted while the window is enabled
        p_win_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tgt_valid[t]) |-> $past(win_en));
        // R4: the bank-select bit is removed, top bit is zero
        p_bank_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_valid[t] |-> !tgt_addr[t*ADDR_W + ADDR_W - 1]);
    end

    for (genvar i = 0; i < N_INI; i++) begin : g_ini_chk
        // R7: an initiator is being served by at most one target
        p_one_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(own_match[i]) <= 1);
    end
endmodule

// File: tb/sim_fetch_router.sv
module sim_fetch_router;
    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [19:0] cfg_wdata;
    logic [3:0]  ini_valid, ini_ready, ini_rsp_valid, ini_rsp_last;
    logic [79:0] ini_addr;
    logic [7:0]  ini_len;
    logic [511:0] ini_rsp_data;
    logic [2:0]  tgt_valid, tgt_ready, tgt_rvalid, tgt_rlast;
    logic [59:0] tgt_addr;
    logic [5:0]  tgt_len;
    logic [383:0] tgt_rdata;

    fetch_router u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ini_valid(ini_valid), .ini_ready(ini_ready), .ini_addr(ini_addr), .ini_len(ini_len),
        .ini_rsp_valid(ini_rsp_valid), .ini_rsp_last(ini_rsp_last), .ini_rsp_data(ini_rsp_data),
        .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr), .tgt_len(tgt_len),
        .tgt_rvalid(tgt_rvalid), .tgt_rlast(tgt_rlast), .tgt_rdata(tgt_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int order_q[$];
    logic [19:0] m_start = 20'h00000;
    logic [19:0] m_end   = 20'hFFFFF;
    logic        m_en    = 1'b0;

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int exp_tgt(input logic [19:0] a);
        if (m_en && a >= m_start && a <= m_end) return a[8] ? 2 : 1;
        return 0;
    endfunction

    function automatic logic [19:0] exp_addr(input logic [19:0] a);
        if (exp_tgt(a) == 0) return a;
        return {1'b0, a[19:9], a[7:0]};
    endfunction

    function automatic logic [127:0] mk_data(input int t, input logic [19:0] a, input int b);
        return {4'(t), a, 8'(b), {24{4'hC}}};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_start = d;
            2'd1: m_end = d;
            2'd2: m_en = d[0];
            default: ;
        endcase
    endtask

    task automatic do_req(input int i, input logic [19:0] a, input logic [1:0] l, input string tag);
        int et;
        logic [19:0] ea;
        int b;
        et = exp_tgt(a);
        ea = exp_addr(a);
        @(negedge clk);
        ini_valid[i] = 1'b1;
        ini_addr[i*20 +: 20] = a;
        ini_len[i*2 +: 2] = l;
        forever begin
            @(negedge clk); #1;
            if (ini_ready[i]) break;
        end
        order_q.push_back(i);
        @(negedge clk);
        ini_valid[i] = 1'b0;
        b = 0;
        while (b <= int'(l)) begin
            #1;
            if (ini_rsp_valid[i]) begin
                chk(ini_rsp_data[i*128 +: 128] == mk_data(et, ea, b), tag,
                    ini_rsp_data[i*128 +: 128], mk_data(et, ea, b));
                chk(ini_rsp_last[i] == (b == int'(l)), "R7 last flag",
                    128'(ini_rsp_last[i]), 128'(b == int'(l)));
                b++;
            end
            if (b <= int'(l)) @(negedge clk);
        end
    endtask

    task automatic responder(input int t);
        logic [19:0] a, pa;
        logic [1:0]  l;
        bit pend;
        pend = 0;
        pa = '0;
        forever begin
            @(negedge clk);
            if (pend && tgt_valid[t])
                chk(tgt_addr[t*20 +: 20] == pa, "R5 held address", 128'(tgt_addr[t*20 +: 20]), 128'(pa));
            pend = 0;
            tgt_ready[t] = ($urandom_range(3) != 0);
            if (tgt_valid[t] && tgt_ready[t]) begin
                a = tgt_addr[t*20 +: 20];
                l = tgt_len[t*2 +: 2];
                @(negedge clk);
                tgt_ready[t] = 1'b0;
                repeat ($urandom_range(2)) @(negedge clk);
                for (int b = 0; b <= int'(l); b++) begin
                    tgt_rvalid[t] = 1'b1;
                    tgt_rlast[t]  = (b == int'(l));
                    tgt_rdata[t*128 +: 128] = mk_data(t, a, b);
                    @(negedge clk);
                    tgt_rvalid[t] = 1'b0;
                    tgt_rlast[t]  = 1'b0;
                    if (b < int'(l) && $urandom_range(3) == 0) @(negedge clk);
                end
            end else if (tgt_valid[t]) begin
                pend = 1;
                pa = tgt_addr[t*20 +: 20];
            end
        end
    endtask

    task automatic rand_worker(input int i, input int n);
        for (int k = 0; k < n; k++) begin
            logic [19:0] a;
            a = 20'($urandom_range(0, 20'h0FFFF));
            do_req(i, a, 2'($urandom_range(3)), "R7 random steering");
        end
    endtask

    task automatic run_all();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(tgt_valid == 3'b000, "R1 target valid at reset", 128'(tgt_valid), 128'(0));
        chk(ini_ready == 4'b0000, "R1 ready at reset", 128'(ini_ready), 128'(0));
        chk(ini_rsp_valid == 4'b0000, "R1 response at reset", 128'(ini_rsp_valid), 128'(0));

        // R6: all four contend for target 0 right after reset
        order_q.delete();
        fork
            do_req(0, 20'h00100, 2'd0, "R1 default route");
            do_req(1, 20'h12345, 2'd1, "R1 default route");
            do_req(2, 20'hFFFFF, 2'd3, "R3 burst uncached");
            do_req(3, 20'h80080, 2'd0, "R1 default route");
        join
        chk(order_q.size() == 4, "R6 grant count", 128'(order_q.size()), 128'(4));
        for (int k = 0; k < 4; k++)
            chk(order_q[k] == k, "R6 round-robin order", 128'(order_q[k]), 128'(k));
        order_q.delete();
        fork
            do_req(3, 20'h00200, 2'd0, "R3 uncached");
            do_req(1, 20'h00300, 2'd2, "R3 uncached");
        join
        chk(order_q[0] == 1 && order_q[1] == 3, "R6 order after wrap",
            128'(order_q[0]), 128'(1));

        // R8: one-cycle latency to target valid
        fork
            do_req(2, 20'h00400, 2'd0, "R3 uncached");
            begin
                @(negedge clk); @(negedge clk);
                chk(tgt_valid[0] == 1'b1, "R8 latency", 128'(tgt_valid[0]), 128'(1));
            end
        join

        // R2: reset bounds cover the whole space once enabled
        cfg_write(2'd2, 20'h1);
        do_req(0, 20'h00000, 2'd0, "R2 reset start bound");
        do_req(1, 20'hFFFFF, 2'd1, "R2 reset end bound");

        cfg_write(2'd0, 20'h04000);
        cfg_write(2'd1, 20'h0BFFF);
        do_req(0, 20'h03FFF, 2'd0, "R3 below window");
        do_req(1, 20'h04000, 2'd0, "R4 start inclusive bank 1");
        do_req(2, 20'h0BFFF, 2'd3, "R4 end inclusive bank 2");
        do_req(3, 20'h0C000, 2'd0, "R3 above window");
        do_req(0, 20'h07F12, 2'd1, "R4 bit strip");

        cfg_write(2'd3, 20'h00000);
        do_req(1, 20'h04100, 2'd0, "R2 spare select ignored");

        // R9: three targets at once
        fork
            do_req(0, 20'h00010, 2'd1, "R9 target 0");
            do_req(1, 20'h05010, 2'd1, "R9 target 1");
            do_req(2, 20'h05110, 2'd1, "R9 target 2");
            begin
                @(negedge clk); @(negedge clk);
                chk(tgt_valid == 3'b111, "R9 concurrent issue", 128'(tgt_valid), 128'(7));
            end
        join

        fork
            rand_worker(0, 40);
            rand_worker(1, 40);
            rand_worker(2, 40);
            rand_worker(3, 40);
        join

        cfg_write(2'd2, 20'h0);
        do_req(3, 20'h04000, 2'd0, "R2 disabled window");
        fork
            rand_worker(0, 10);
            rand_worker(1, 10);
            rand_worker(2, 10);
            rand_worker(3, 10);
        join
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        ini_valid = '0; ini_addr = '0; ini_len = '0;
        tgt_ready = '0; tgt_rvalid = '0; tgt_rlast = '0; tgt_rdata = '0;
        fork
            responder(0);
            responder(1);
            responder(2);
        join_none
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule